// File: doc/BRIEF.md
# Grouped Interrupt Combiner

This block gathers a wide bank of level-sensitive interrupt request lines into groups of eight sources and produces one output line per group. A group line is high whenever at least one of its sources is both pending and enabled. Pending bits are not latched. Each one tracks its input level, so a source that drops its request also drops its share of the group line.

Software reaches the block through a flat 32-bit register window. The window is divided into 16-byte quads, and each quad serves four neighbouring groups, one byte lane per group. Inside a quad, enables are changed only through a write-one-to-set word and a write-one-to-clear word. Two further words report raw pending and masked pending status. After the last quad, one or more read-only summary words hold the post-mask state of every group line, one bit per group. A parameter limits how many groups are live. This lets the same block serve as a smaller combiner whose upper groups never assert.

Top module: `irq_combiner`

## Requirements
- R1: Input line n belongs to group n/8 at source bit n%8. Its pending bit holds the input level sampled at the previous clock edge, set while the input is high and cleared once it is low.
- R2: Group line g is registered. One clock edge after any input or enable change, it equals the OR over the eight bits of (pending AND enable) of group g.
- R3: A write to word 0 of quad q (byte offset 16q) ORs the 1 bits of byte lane k into the enable mask of group 4q+k. Zero bits leave enables unchanged.
- R4: A write to word 1 of quad q (offset 16q+4) clears each enable bit of group 4q+k whose bit in byte lane k is 1. Zero bits leave enables unchanged.
- R5: In every quad word, bits 8k+7..8k belong to group 4q+k, and the quad index is address bits [ADDR_W-1:4].
- R6: Word 2 of a quad (offset 16q+8) reads the raw pending bytes of its four groups. Word 3 (offset 16q+12) reads pending AND enable. Words 0 and 1 read as zero.
- R7: Summary word j, at byte offset 4*NUM_GROUPS+4j (0x100 and 0x104 by default), holds group line 32j+i in bit i. Any other offset past the quads reads zero.
- R8: Writes to words 2 and 3 of a quad, to the summary words, or to any offset beyond the quads change no enable bit.
- R9: Groups numbered ACTIVE_GROUPS and above ignore their inputs and enable writes. Their pending status reads zero and their group lines stay low.
- R10: Reset clears every enable and pending bit, and every group line is low after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_in | input | NUM_GROUPS*8 | Level interrupt sources, line n in group n/8 |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| addr | input | ADDR_W | Byte address of the register access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational from registered state |
| grp_out | output | NUM_GROUPS | One registered output line per group |

## Verification
The bench targets the points where a combiner is easy to get subtly wrong. A design that latched pending bits would keep a group line high after its source drops. A design that wrote enables straight from the data word would let a zero in the set word or the clear word wipe out other enables. A design that mapped byte lanes or quads wrongly would light the neighbouring group. The bench also writes to the status and summary words, which must not alter enables, and drives the groups above the live count, which must stay silent. Finally it checks the output one edge after each change and not earlier, which catches both a missing register stage and an extra one.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   localparam int SRC_PER_GRP  = 8;
   localparam int GRP_PER_QUAD = 4;
   localparam int QUAD_BYTES   = 16;

   localparam logic [1:0] WORD_SET = 2'd0;
   localparam logic [1:0] WORD_CLR = 2'd1;
   localparam logic [1:0] WORD_RAW = 2'd2;
   localparam logic [1:0] WORD_MSK = 2'd3;

   typedef logic [SRC_PER_GRP-1:0] src_vec_t;
endpackage

// File: rtl/irqc_group.sv
module irqc_group
   import irqc_pkg::*;
#(
   parameter bit LIVE = 1'b1
) (
   input  logic     clk,
   input  logic     rst_n,
   input  src_vec_t src,
   input  src_vec_t set_m,
   input  src_vec_t clr_m,
   output src_vec_t pend_o,
   output src_vec_t en_o,
   output logic     out_o
);
   generate
      if (LIVE) begin : g_live
         src_vec_t pend_q, en_q, en_nx;
         logic     out_q;

         always_comb en_nx = (en_q | set_m) & ~clr_m;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               pend_q <= '0;
               en_q   <= '0;
               out_q  <= 1'b0;
            end else begin
               pend_q <= src;
               en_q   <= en_nx;
               out_q  <= |(src & en_nx);
            end
         end

         assign pend_o = pend_q;
         assign en_o   = en_q;
         assign out_o  = out_q;
      end else begin : g_dead
         logic unused_dead;
         assign unused_dead = ^{clk, rst_n, src, set_m, clr_m};
         assign pend_o = '0;
         assign en_o   = '0;
         assign out_o  = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/irqc_wdec.sv
module irqc_wdec
   import irqc_pkg::*;
#(
   parameter int NUM_GROUPS = 64,
   parameter int ADDR_W     = 9
) (
   input  logic                           wr_en,
   input  logic [ADDR_W-1:0]              addr,
   input  logic [31:0]                    wdata,
   output logic [NUM_GROUPS*SRC_PER_GRP-1:0] set_flat,
   output logic [NUM_GROUPS*SRC_PER_GRP-1:0] clr_flat
);
   logic unused_low;
   assign unused_low = ^addr[1:0];

   generate
      for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
         localparam int Q = g / GRP_PER_QUAD;
         localparam int L = g % GRP_PER_QUAD;
         logic hit;
         assign hit = wr_en && (int'(addr[ADDR_W-1:4]) == Q);
         assign set_flat[g*SRC_PER_GRP +: SRC_PER_GRP] =
            (hit && addr[3:2] == WORD_SET) ? wdata[L*SRC_PER_GRP +: SRC_PER_GRP] : '0;
         assign clr_flat[g*SRC_PER_GRP +: SRC_PER_GRP] =
            (hit && addr[3:2] == WORD_CLR) ? wdata[L*SRC_PER_GRP +: SRC_PER_GRP] : '0;
      end
   endgenerate
endmodule

// File: rtl/irqc_rmux.sv
module irqc_rmux
   import irqc_pkg::*;
#(
   parameter int NUM_GROUPS = 64,
   parameter int ADDR_W     = 9
) (
   input  logic [ADDR_W-1:0]                 addr,
   input  logic [NUM_GROUPS*SRC_PER_GRP-1:0] pend_flat,
   input  logic [NUM_GROUPS*SRC_PER_GRP-1:0] en_flat,
   input  logic [NUM_GROUPS-1:0]             out_vec,
   output logic [31:0]                       rdata
);
   localparam int NQUAD     = NUM_GROUPS / GRP_PER_QUAD;
   localparam int SUM_WORDS = (NUM_GROUPS + 31) / 32;
   localparam int SUM_WBASE = NUM_GROUPS;

   logic unused_low;
   assign unused_low = ^addr[1:0];

   int quad, widx;

   always_comb begin
      quad  = int'(addr[ADDR_W-1:4]);
      widx  = int'(addr[ADDR_W-1:2]);
      rdata = '0;
      if (quad < NQUAD) begin
         for (int g = 0; g < NUM_GROUPS; g++) begin
            if (g / GRP_PER_QUAD == quad) begin
               if (addr[3:2] == WORD_RAW)
                  rdata[(g%GRP_PER_QUAD)*SRC_PER_GRP +: SRC_PER_GRP] =
                     pend_flat[g*SRC_PER_GRP +: SRC_PER_GRP];
               else if (addr[3:2] == WORD_MSK)
                  rdata[(g%GRP_PER_QUAD)*SRC_PER_GRP +: SRC_PER_GRP] =
                     pend_flat[g*SRC_PER_GRP +: SRC_PER_GRP] &
                     en_flat[g*SRC_PER_GRP +: SRC_PER_GRP];
            end
         end
      end else if (widx >= SUM_WBASE && widx < SUM_WBASE + SUM_WORDS) begin
         for (int g = 0; g < NUM_GROUPS; g++) begin
            if (g / 32 == widx - SUM_WBASE)
               rdata[g%32] = out_vec[g];
         end
      end
   end
endmodule

// File: rtl/irq_combiner.sv
module irq_combiner
   import irqc_pkg::*;
#(
   parameter int NUM_GROUPS    = 64,
   parameter int ACTIVE_GROUPS = 64,
   parameter int ADDR_W        = 9
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [NUM_GROUPS*SRC_PER_GRP-1:0] irq_in,
   input  logic                              wr_en,
   input  logic [ADDR_W-1:0]                 addr,
   input  logic [31:0]                       wdata,
   output logic [31:0]                       rdata,
   output logic [NUM_GROUPS-1:0]             grp_out
);
   localparam int NSRC        = NUM_GROUPS * SRC_PER_GRP;
   localparam int SUM_WORDS   = (NUM_GROUPS + 31) / 32;
   localparam int SPACE_BYTES = NUM_GROUPS * 4 + SUM_WORDS * 4;

   generate
      if (NUM_GROUPS % GRP_PER_QUAD != 0) begin : g_chk_quad
         $error("NUM_GROUPS must be a multiple of four");
      end
      if (ACTIVE_GROUPS < 1 || ACTIVE_GROUPS > NUM_GROUPS) begin : g_chk_active
         $error("ACTIVE_GROUPS out of range");
      end
      if (ADDR_W < 5 || SPACE_BYTES > (1 << ADDR_W)) begin : g_chk_addr
         $error("ADDR_W too small for the register window");
      end
   endgenerate

   logic [NSRC-1:0] set_flat, clr_flat, pend_flat, en_flat;

   irqc_wdec #(.NUM_GROUPS(NUM_GROUPS), .ADDR_W(ADDR_W)) u_wdec (
      .wr_en   (wr_en),
      .addr    (addr),
      .wdata   (wdata),
      .set_flat(set_flat),
      .clr_flat(clr_flat)
   );

   generate
      for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
         irqc_group #(.LIVE(g < ACTIVE_GROUPS)) u_grp (
            .clk   (clk),
            .rst_n (rst_n),
            .src   (irq_in[g*SRC_PER_GRP +: SRC_PER_GRP]),
            .set_m (set_flat[g*SRC_PER_GRP +: SRC_PER_GRP]),
            .clr_m (clr_flat[g*SRC_PER_GRP +: SRC_PER_GRP]),
            .pend_o(pend_flat[g*SRC_PER_GRP +: SRC_PER_GRP]),
            .en_o  (en_flat[g*SRC_PER_GRP +: SRC_PER_GRP]),
            .out_o (grp_out[g])
         );
      end
   endgenerate

   irqc_rmux #(.NUM_GROUPS(NUM_GROUPS), .ADDR_W(ADDR_W)) u_rmux (
      .addr     (addr),
      .pend_flat(pend_flat),
      .en_flat  (en_flat),
      .out_vec  (grp_out),
      .rdata    (rdata)
   );
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
   parameter int NUM_GROUPS    = 64,
   parameter int ACTIVE_GROUPS = 64,
   parameter int ADDR_W        = 9
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [NUM_GROUPS*8-1:0] irq_in,
   input logic                    wr_en,
   input logic [ADDR_W-1:0]       addr,
   input logic [31:0]             wdata,
   input logic [31:0]             rdata,
   input logic [NUM_GROUPS-1:0]   grp_out
);
   localparam int NQUAD = NUM_GROUPS / 4;

   AST_RESET_CLEARS: assert property (@(posedge clk)
      !rst_n |=> (grp_out == '0)); // R10

   AST_STROBE_WORDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(addr[ADDR_W-1:4]) < NQUAD && addr[3:2] < 2'd2) |-> (rdata == '0)); // R6

   generate
      if (NUM_GROUPS >= 32) begin : g_sum
         AST_SUMMARY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
            (int'(addr[ADDR_W-1:2]) == NUM_GROUPS) |-> (rdata == grp_out[31:0])); // R7
      end
      for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
         AST_QUIET_GROUP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_in[g*8 +: 8] == 8'h00) |=> !grp_out[g]); // R2
         AST_CLEAR_ALL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && int'(addr[ADDR_W-1:4]) == g/4 && addr[3:2] == 2'd1 &&
             wdata[(g%4)*8 +: 8] == 8'hFF) |=> !grp_out[g]); // R4
         if (g >= ACTIVE_GROUPS) begin : g_dead
            AST_DEAD_GROUP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
               !grp_out[g]); // R9
         end
      end
   endgenerate
endmodule

bind irq_combiner irqc_checker #(
   .NUM_GROUPS   (NUM_GROUPS),
   .ACTIVE_GROUPS(ACTIVE_GROUPS),
   .ADDR_W       (ADDR_W)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .irq_in (irq_in),
   .wr_en  (wr_en),
   .addr   (addr),
   .wdata  (wdata),
   .rdata  (rdata),
   .grp_out(grp_out)
);

// File: tb/irq_combiner_test.sv
module irq_combiner_test;
   localparam int PERIOD = 10;
   localparam int NG     = 64;
   localparam int ACT    = 60;
   localparam int AW     = 9;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NG*8-1:0] irq_in = '0;
   logic            wr_en = 1'b0;
   logic [AW-1:0]   addr = '0;
   logic [31:0]     wdata = '0;
   logic [31:0]     rdata;
   logic [NG-1:0]   grp_out;

   int checks = 0;
   int fails  = 0;

   logic [7:0]    m_pend [NG];
   logic [7:0]    m_en   [NG];
   logic [NG-1:0] m_out;

   always #(PERIOD/2) clk = ~clk;

   irq_combiner #(.NUM_GROUPS(NG), .ACTIVE_GROUPS(ACT), .ADDR_W(AW)) uut (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .grp_out(grp_out)
   );

   // behavioural reference model, advanced on each rising edge
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int g = 0; g < NG; g++) begin m_pend[g] = 8'h00; m_en[g] = 8'h00; end
         m_out = '0;
      end else begin
         for (int g = 0; g < ACT; g++) begin
            if (wr_en && (int'(addr) >> 4) == g/4) begin
               if (addr[3:2] == 2'd0) m_en[g] = m_en[g] | wdata[(g%4)*8 +: 8];
               if (addr[3:2] == 2'd1) m_en[g] = m_en[g] & ~wdata[(g%4)*8 +: 8];
            end
            m_pend[g] = irq_in[g*8 +: 8];
         end
         for (int g = 0; g < NG; g++) m_out[g] = |(m_pend[g] & m_en[g]);
      end
   end

   function automatic logic [31:0] model_read(input logic [AW-1:0] a);
      logic [31:0] v = '0;
      int q = int'(a) >> 4;
      int w = int'(a) >> 2;
      if (q < NG/4) begin
         for (int k = 0; k < 4; k++) begin
            if (a[3:2] == 2'd2) v[k*8 +: 8] = m_pend[4*q+k];
            if (a[3:2] == 2'd3) v[k*8 +: 8] = m_pend[4*q+k] & m_en[4*q+k];
         end
      end else if (w == NG) v = m_out[31:0];
      else if (w == NG + 1) v = m_out[63:32];
      return v;
   endfunction

   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // every cycle: group lines against the model
   always @(negedge clk) begin
      if (rst_n) check(grp_out === m_out, "R2 per-cycle grp_out", grp_out, m_out);
   end

   task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      addr = a;
      #1;
      check(rdata === exp, tag, {32'h0, rdata}, {32'h0, exp});
   endtask

   task automatic finish_run;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      #(PERIOD * 200000);
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(grp_out === '0, "R10 outputs after reset", grp_out, 0);
      rd(9'h008, 32'h0, "R10 raw pending after reset");

      // R1 / R5: pending follows inputs, lane mapping
      irq_in[5] = 1'b1; irq_in[77] = 1'b1; irq_in[500] = 1'b1;
      @(negedge clk);
      rd(9'h008, 32'h0000_0020, "R1 raw group0 bit5");
      rd(9'h028, 32'h0000_2000, "R5 raw group9 lane1");
      rd(9'h0F8, 32'h0, "R9 raw dead group62");

      // R3 set, R6 masked and strobe reads
      wr(9'h020, 32'h0000_2000);
      check(grp_out[9] === 1'b1, "R3 group9 after set", grp_out[9], 1);
      rd(9'h02C, 32'h0000_2000, "R6 masked quad2");
      rd(9'h020, 32'h0, "R6 set word reads zero");
      rd(9'h024, 32'h0, "R6 clear word reads zero");
      wr(9'h020, 32'h0);
      rd(9'h02C, 32'h0000_2000, "R3 zero set keeps enable");

      // R8 ignored writes
      wr(9'h02C, 32'h0); wr(9'h028, 32'hFFFF_FFFF);
      wr(9'h100, 32'hFFFF_FFFF); wr(9'h104, 32'hFFFF_FFFF);
      rd(9'h02C, 32'h0000_2000, "R8 status writes ignored");
      rd(9'h00C, 32'h0, "R8 no stray enable group0");
      rd(9'h100, 32'h0000_0200, "R7 summary low word");
      rd(9'h104, 32'h0, "R7 summary high word");
      rd(9'h108, 32'h0, "R7 past summary reads zero");

      // R4 clear with zero lanes harmless
      wr(9'h024, 32'hFFFF_00FF);
      rd(9'h02C, 32'h0000_2000, "R4 zero clear bits keep enable");
      wr(9'h024, 32'h0000_2000);
      check(grp_out[9] === 1'b0, "R4 group9 after clear", grp_out[9], 0);
      rd(9'h02C, 32'h0, "R4 masked after clear");

      // R9 dead groups
      wr(9'h0F0, 32'hFFFF_FFFF);
      irq_in[511:480] = '1;
      @(negedge clk); @(negedge clk);
      check(grp_out[63:60] === 4'h0, "R9 dead groups low", grp_out[63:60], 0);
      rd(9'h0FC, 32'h0, "R9 dead masked zero");

      // R1 / R2 latency: group0 follows level one edge later
      wr(9'h000, 32'h0000_00FF);
      check(grp_out[0] === 1'b1, "R2 group0 asserted", grp_out[0], 1);
      @(negedge clk);
      irq_in[5] = 1'b0;
      #1;
      check(grp_out[0] === 1'b1, "R2 not before edge", grp_out[0], 1);
      @(negedge clk);
      check(grp_out[0] === 1'b0, "R1 level drop releases", grp_out[0], 0);

      // random traffic against the model
      for (int i = 0; i < 4000; i++) begin
         @(negedge clk);
         if (($urandom % 4) == 0)
            for (int w = 0; w < NG*8/32; w++) irq_in[w*32 +: 32] = $urandom & $urandom;
         wr_en = (($urandom % 3) == 0);
         addr  = AW'(($urandom % 68) * 4);
         wdata = $urandom;
         #1;
         check(rdata === model_read(addr), "R6 random read", {32'h0, rdata}, {32'h0, model_read(addr)});
      end
      @(negedge clk);
      wr_en = 1'b0;

      // reset mid-run
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      irq_in = '0;
      check(grp_out === '0, "R10 reset mid-run", grp_out, 0);
      rd(9'h00C, 32'h0, "R10 masked after reset");
      finish_run();
   end
endmodule